// File: doc/BRIEF.md
# Comparator Glitch Filter

This block cleans up the one-bit decision of an analog comparator before the rest of the chip uses it. The raw bit arrives with no timing relationship to the bus clock, so it is first brought into the clock domain through a two-stage synchronizer. An optional polarity flip is applied next. The result is the unfiltered output.

The filtered output comes from a digital filter that reads the unfiltered bit only at sample points. Sample points come from an internal divider that fires once every programmed number of bus clocks, or, in external-sample mode, from a strobe input. The filtered output moves to a new level only after a programmed number of consecutive samples all show that level. Some settings bypass the filter, and one setting forces the output low.

A select input picks either the filtered or the unfiltered bit for the main output. Changing the period or the sample count restarts both the divider and the agreement run.

Top module: `cmp_glitch_filter`

## Requirements
- R1: `unfilt_out` equals `raw_in` XOR `invert`, with `raw_in` sampled two rising clock edges earlier.
- R2: With `cnt_cfg` = N in 2..7 and a sample source active, `filt_out` changes to a value v only at the sample point that completes a run of N consecutive samples equal to v. A shorter run of differing samples leaves it unchanged. `filt_out` changes only at sample points.
- R3: With `cnt_cfg` = 1, `filt_out` takes the sampled value at every sample point.
- R4: With `cnt_cfg` = 0 and `ext_mode` = 0, `filt_out` equals `unfilt_out`.
- R5: With `cnt_cfg` = 0 and `ext_mode` = 1, `filt_out` is 0.
- R6: With `per_cfg` = 0, `ext_mode` = 0 and `cnt_cfg` nonzero, `filt_out` equals `unfilt_out`.
- R7: With `ext_mode` = 0 and `per_cfg` = P > 0, sample points occur every P clocks. The first one comes at the P-th edge after the edge that registers a restart.
- R8: With `ext_mode` = 1, `per_cfg` is ignored. A sample point is each clock edge at which `strobe_in` is 1.
- R9: `invert` = 1 inverts the comparator bit before both the filter and `unfilt_out`.
- R10: `sel_out` equals `unfilt_out` when `use_raw` = 1 and `filt_out` when `use_raw` = 0.
- R11: A synchronous active-low reset clears the synchronizer, the divider, the agreement run and the filtered state, so `filt_out` is 0 after reset in filter mode.
- R12: At the first edge after `per_cfg` or `cnt_cfg` changes value, the divider and the agreement run restart and no sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | 1 | Asynchronous comparator decision |
| strobe_in | input | 1 | External sample strobe, one-cycle synchronous pulses |
| ext_mode | input | 1 | 1: sample on strobe, 0: sample on internal divider |
| invert | input | 1 | Polarity flip of the comparator bit |
| use_raw | input | 1 | 1: main output shows the unfiltered bit |
| cnt_cfg | input | CNT_W (3) | Consecutive samples needed to accept a new level |
| per_cfg | input | PER_W (8) | Internal sample period in clocks |
| filt_out | output | 1 | Filtered bit |
| unfilt_out | output | 1 | Synchronized, optionally inverted bit |
| sel_out | output | 1 | Selected output bit |

## Verification
The assertions check, on every cycle, that the synchronizer delay holds and that the filtered state never moves between sample points. They also check that a strobe-less cycle in external mode takes no sample, that two back-to-back internal ticks happen only with a period of one, and that the run clears on restart and after reset. The exact cycle in which a run of agreeing samples is accepted, the rejection of short glitches, the degenerate bypass and force-low settings, and the phase of the first tick after a configuration change are only visible in the bench scenarios. Those scenarios sweep every count, several periods, both sample sources and both polarities against an arithmetic reference.

// File: rtl/cmpf_pkg.sv
// Shared defaults and the output-mode decode for the comparator glitch filter.
package cmpf_pkg;
    localparam int CNT_W_DEF = 3;
    localparam int PER_W_DEF = 8;

    // Source of the filtered output.
    typedef enum logic [1:0] {
        FM_FILTER = 2'd0,
        FM_PASS   = 2'd1,
        FM_ZERO   = 2'd2
    } fmode_e;

    // Degenerate settings: count zero bypasses (or forces low when strobed),
    // a zero period bypasses in internal mode.
    function automatic fmode_e pick_mode(input logic cnt_zero, input logic ext,
                                         input logic per_zero);
        if (cnt_zero && ext)                 return FM_ZERO;
        else if (cnt_zero || (!ext && per_zero)) return FM_PASS;
        else                                 return FM_FILTER;
    endfunction
endpackage

// File: rtl/cmpf_sync.sv
// Two-flop synchronizer for the asynchronous comparator bit, followed by the
// polarity flip. Assumes raw_in may change at any time relative to clk.
module cmpf_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic invert,
    output logic unfilt
);
    logic s1_q, s2_q;

    // Capture and re-time the raw bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= raw_in;
            s2_q <= s1_q;
        end
    end

    assign unfilt = s2_q ^ invert;

    // R1
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (s2_q == $past(raw_in, 2)));
endmodule

// File: rtl/cmpf_tick.sv
// Sample-point generator: an internal divider of per_cfg clocks, or the
// external strobe. Assumes strobe_in is a synchronous one-cycle pulse.
module cmpf_tick #(
    parameter int PER_W = cmpf_pkg::PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             strobe_in,
    input  logic             restart,
    input  logic [PER_W-1:0] per_cfg,
    output logic             tick
);
    logic [PER_W-1:0] div_q;
    logic             div_end;

    assign div_end = (per_cfg != '0) && (div_q == per_cfg - 1'b1);

    // Count clocks within one period; hold at zero when unused or restarting.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  div_q <= '0;
        else if (restart || ext_mode || per_cfg == '0) div_q <= '0;
        else if (div_end)                            div_q <= '0;
        else                                         div_q <= div_q + 1'b1;
    end

    // Select the sample source; a restart cycle never samples.
    always_comb begin
        if (ext_mode) tick = strobe_in && !restart;
        else          tick = div_end && !restart;
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && tick && per_cfg > PER_W'(1)) |=> (!tick || ext_mode));
endmodule

// File: rtl/cmpf_agree.sv
// Consecutive-sample agreement filter. On each tick the sample extends or
// restarts a saturating run; the filtered state takes the sample once the
// run reaches cnt_cfg. Assumes tick is already qualified by restart.
module cmpf_agree #(
    parameter int CNT_W = cmpf_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             sample,
    input  logic [CNT_W-1:0] cnt_cfg,
    output logic             filt_q
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    logic [CNT_W-1:0] run_q, run_nx;
    logic             last_q;

    // Length of the run including the current sample.
    always_comb begin
        if (sample == last_q) run_nx = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        else                  run_nx = CNT_W'(1);
    end

    // Advance the run on each tick and accept the level when it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
            filt_q <= 1'b0;
        end else if (restart) begin
            run_q  <= '0;
        end else if (tick) begin
            run_q  <= run_nx;
            last_q <= sample;
            if (run_nx >= cnt_cfg) filt_q <= sample;
        end
    end

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt_q));
    // R12
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (run_q == '0));
    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (run_q == '0 && filt_q == 1'b0));
endmodule

// File: rtl/cmp_glitch_filter.sv
// Comparator output glitch filter top: synchronizer, sample-point generator,
// agreement filter and output selection. Assumes the configuration inputs are
// quasi-static register fields in the clk domain.
module cmp_glitch_filter #(
    parameter int CNT_W = cmpf_pkg::CNT_W_DEF,
    parameter int PER_W = cmpf_pkg::PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_in,
    input  logic             strobe_in,
    input  logic             ext_mode,
    input  logic             invert,
    input  logic             use_raw,
    input  logic [CNT_W-1:0] cnt_cfg,
    input  logic [PER_W-1:0] per_cfg,
    output logic             filt_out,
    output logic             unfilt_out,
    output logic             sel_out
);
    import cmpf_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic             restart, tick, unfilt, filt_q;
    fmode_e           mode;

    // Remember the last configuration so that a new value can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else begin
            cnt_q <= cnt_cfg;
            per_q <= per_cfg;
        end
    end

    assign restart = (cnt_cfg != cnt_q) || (per_cfg != per_q);

    cmpf_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_in),
        .invert (invert),
        .unfilt (unfilt)
    );

    cmpf_tick #(.PER_W(PER_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .strobe_in (strobe_in),
        .restart   (restart),
        .per_cfg   (per_cfg),
        .tick      (tick)
    );

    cmpf_agree #(.CNT_W(CNT_W)) u_agree (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .sample  (unfilt),
        .cnt_cfg (cnt_cfg),
        .filt_q  (filt_q)
    );

    assign mode = pick_mode(cnt_cfg == '0, ext_mode, per_cfg == '0);

    // Choose the filtered result, the bypass or the forced low.
    always_comb begin
        case (mode)
            FM_PASS: filt_out = unfilt;
            FM_ZERO: filt_out = 1'b0;
            default: filt_out = filt_q;
        endcase
    end

    assign unfilt_out = unfilt;
    assign sel_out    = use_raw ? unfilt : filt_out;

    // R8
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !strobe_in) |=> $stable(filt_q));
endmodule

// File: tb/cmp_glitch_filter_bench.sv
module cmp_glitch_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw = 1'b0, strobe = 1'b0, ext = 1'b0, inv = 1'b0, use_raw = 1'b0;
    logic [2:0] cnt = 3'd1;
    logic [7:0] per = 8'd1;
    logic       filt_out, unfilt_out, sel_out;

    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;

    always #10 clk = ~clk;

    cmp_glitch_filter u_cmp_glitch_filter (
        .clk(clk), .rst_n(rst_n), .raw_in(raw), .strobe_in(strobe),
        .ext_mode(ext), .invert(inv), .use_raw(use_raw),
        .cnt_cfg(cnt), .per_cfg(per),
        .filt_out(filt_out), .unfilt_out(unfilt_out), .sel_out(sel_out)
    );

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0b exp=%0b t=%0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Arithmetic reference: age counts clocks since the last restart.
    bit m_s1, m_s2, m_last, m_fq;
    int m_age, m_run;
    logic [2:0] m_pc;
    logic [7:0] m_pp;

    always @(posedge clk) begin
        bit chg, tk, smp;
        int nr;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_last = 0; m_fq = 0;
            m_age = 0; m_run = 0; m_pc = '0; m_pp = '0;
        end else begin
            chg = (cnt != m_pc) || (per != m_pp);
            smp = m_s2 ^ inv;
            if (ext) tk = strobe && !chg;
            else     tk = (per != 0) && !chg && (((m_age + 1) % int'(per)) == 0);
            if (chg || ext || per == 0) m_age = 0; else m_age = m_age + 1;
            if (chg) m_run = 0;
            else if (tk) begin
                nr = (m_run > 0 && smp == m_last) ? ((m_run < 7) ? m_run + 1 : 7) : 1;
                if (nr >= int'(cnt)) m_fq = smp;
                m_run  = nr;
                m_last = smp;
            end
            m_s2 = m_s1; m_s1 = raw; m_pc = cnt; m_pp = per;
        end
    end

    function automatic string tag_for();
        if (cnt == 0 && ext)        return "R5";
        if (cnt == 0)               return "R4";
        if (!ext && per == 0)       return "R6";
        if (ext)                    return "R8";
        if (cnt == 1)               return "R3";
        return "R2";
    endfunction

    // Compare every cycle against the reference, away from the clock edge.
    always @(negedge clk) begin
        bit eu, ef;
        if (chk_en) begin
            eu = m_s2 ^ inv;
            if (cnt == 0 && ext)                 ef = 1'b0;
            else if (cnt == 0 || (!ext && per == 0)) ef = eu;
            else                                 ef = m_fq;
            check(unfilt_out, eu, inv ? "R9" : "R1", "unfilt");
            check(filt_out, ef, tag_for(), "filt");
            check(sel_out, use_raw ? eu : ef, "R10", "sel");
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        // R11: reset state with raw high
        raw = 1'b1;
        step(3);
        chk_en = 1'b1;
        check(filt_out, 1'b0, "R11", "filt in reset");
        check(unfilt_out, 1'b0, "R11", "unfilt in reset");
        check(sel_out, 1'b0, "R11", "sel in reset");
        rst_n = 1'b1;
        // R1: two-edge synchronizer latency
        step(1); check(unfilt_out, 1'b0, "R1", "after 1 edge");
        step(1); check(unfilt_out, 1'b1, "R1", "after 2 edges");
        raw = 1'b0; step(12);

        // R2: short glitch rejected, long run accepted on the third sample
        cnt = 3'd3; per = 8'd1; step(12);
        raw = 1'b1; step(2); raw = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step(1); check(filt_out, 1'b0, "R2", "glitch rejected");
        end
        step(4);
        raw = 1'b1;
        step(4); check(filt_out, 1'b0, "R2", "before third sample");
        step(1); check(filt_out, 1'b1, "R2", "on third sample");
        // R11: mid-run reset clears filtered state
        rst_n = 1'b0; step(1);
        check(filt_out, 1'b0, "R11", "filt after reset");
        rst_n = 1'b1; raw = 1'b0; step(12);

        // R7 and R12: restart, then a tick every fourth clock
        cnt = 3'd1; per = 8'd1; step(10);
        per = 8'd4; raw = 1'b1;
        step(4); check(filt_out, 1'b0, "R12", "no sample before period after restart");
        step(1); check(filt_out, 1'b1, "R7", "first tick at period");
        raw = 1'b0;
        step(3); check(filt_out, 1'b1, "R7", "held between ticks");
        step(1); check(filt_out, 1'b0, "R7", "second tick");

        // R8: strobe defines samples, period ignored
        ext = 1'b1; cnt = 3'd1; per = 8'd5; raw = 1'b0; step(4);
        strobe = 1'b1; step(1); strobe = 1'b0;
        raw = 1'b1; step(10);
        check(filt_out, 1'b0, "R8", "no strobe no sample");
        strobe = 1'b1; step(1); strobe = 1'b0;
        check(filt_out, 1'b1, "R8", "strobe samples");

        // R5 and R10: count zero with strobe mode forces low
        cnt = 3'd0; step(3);
        check(filt_out, 1'b0, "R5", "forced low");
        check(unfilt_out, 1'b1, "R5", "unfilt still high");
        use_raw = 1'b1; step(1); check(sel_out, 1'b1, "R10", "select raw");
        use_raw = 1'b0; step(1); check(sel_out, 1'b0, "R10", "select filtered");

        // R4: count zero, internal mode passes through
        ext = 1'b0; per = 8'd3; step(2);
        check(filt_out, 1'b1, "R4", "bypass high");
        raw = 1'b0; step(3); check(filt_out, 1'b0, "R4", "bypass low");

        // R6: zero period passes through
        cnt = 3'd3; per = 8'd0; raw = 1'b1; step(3);
        check(filt_out, 1'b1, "R6", "zero period bypass");

        // R9: inversion reaches both paths
        inv = 1'b1; step(1);
        check(unfilt_out, 1'b0, "R9", "inverted unfilt");
        check(filt_out, 1'b0, "R9", "inverted filt");
        inv = 1'b0;

        // Sweep every count over several periods and both sample sources.
        lfsr = 16'hACE1;
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 8; c++) begin
                for (int p = 0; p < 5; p++) begin
                    ext = e[0]; cnt = c[2:0];
                    per = (p == 4) ? 8'd7 : 8'(p);
                    inv = p[0]; use_raw = c[0];
                    for (int k = 0; k < 40; k++) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        if (lfsr[2:0] == 3'd0) raw = ~raw;
                        strobe = lfsr[5] & lfsr[7];
                        step(1);
                    end
                end
            end
        end
        strobe = 1'b0;
        step(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule